// File: doc/BRIEF.md
# Two-Bank Cascaded Interrupt Controller

This block collects sixteen level-sensitive, active-low interrupt requests and splits them into two banks of eight. The low bank holds sources 0 to 7, which are the PCI-side requests. The high bank holds sources 8 to 15, the miscellaneous requests. Each bank has a mask byte, where a one blocks the matching source, and a read-only status byte that shows the live request lines. A route byte decides whether the pen-down source drives its own direct interrupt line. A spare control byte is kept for software. All six bytes are reached through a simple byte-wide register bus with single-cycle strobes.

The controller always works out which unmasked requesting source has the highest priority. Every low-bank source ranks above every high-bank source. Within a bank, the lowest bit wins. The block drives one shared cascade interrupt whenever such a source exists. Software acknowledges a level source by setting its mask bit and re-enables it by clearing that bit.

Two high-bank bits are not ordinary sources. High bit 1 reads back as a summary of the low bank. High bit 4 is the pen-down input and never takes part in the cascade. The block holds no state machine. Its only state is the register file and the registered read-data byte.

Top module: `cic_top`

## Requirements
- R1: After reset, both mask bytes and the route byte read 0xFF, the control byte reads 0x00, and `cascade_irq`, `direct_irq` and `pick_valid` are low while no source requests.
- R2: Writes to offsets 0 (low mask), 2 (route), 3 (high mask) and 5 (control) are stored and read back. Read data appears on `bus_rdata` in the cycle after the `bus_rd` strobe and holds between reads. Offsets 6 and 7 read 0x00, and writes to them have no effect.
- R3: Offset 1 reads `src_n[7:0]` directly. Writes to offsets 1 and 4 are ignored.
- R4: Offset 4 reads `src_n[15:8]`, except that bit 1 is replaced by a low-bank summary. That bit is 0 when any unmasked low-bank source requests and 1 otherwise.
- R5: A source requests when its `src_n` bit is 0. A mask bit of 1 removes its source from `cascade_irq` and `pick_*`, and a mask bit of 0 admits it.
- R6: Any unmasked requesting low-bank source is reported ahead of every high-bank source.
- R7: Within a bank, the requesting unmasked source with the lowest index is reported.
- R8: Sources 9 (the summary position) and 12 (pen-down) are never reported on `pick_*` and never raise `cascade_irq`.
- R9: `direct_irq` is high exactly when `src_n[12]` is 0 and route bit 1 is 0, whatever the mask bytes hold. Writing 0xFD to the route byte therefore enables the direct line.
- R10: `cascade_irq` is high exactly while some reportable source is pending. It follows levels combinationally, so setting that source's mask bit (acknowledge) drops it and clearing the bit restores it.
- R11: `pick_id` is the 4-bit source number, with high-bank sources numbered 8 to 15. It reads 0 whenever `pick_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| src_n | input | 16 | Active-low level requests, sources 0 to 15 |
| cascade_irq | output | 1 | Shared interrupt to the parent controller |
| direct_irq | output | 1 | Dedicated pen-down interrupt |
| pick_valid | output | 1 | A reportable source is pending |
| pick_id | output | 4 | Number of the highest-priority pending source |

## Verification
A register write takes effect at the clock edge that samples the strobe. From that edge, the mask and route values feed combinational logic, so `cascade_irq`, `direct_irq` and `pick_*` are already settled by the following falling edge. A change on `src_n` reaches those outputs within the same cycle, with no register on the path. Read data needs one edge: `bus_rdata` is valid from the falling edge after the strobe cycle. The bench therefore drives everything at falling edges and samples either one time unit after a source change, or one full cycle after a strobe.

// File: rtl/cic_pkg.sv
package cic_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_LO_MASK = 3'd0,
        OFS_LO_STAT = 3'd1,
        OFS_ROUTE   = 3'd2,
        OFS_HI_MASK = 3'd3,
        OFS_HI_STAT = 3'd4,
        OFS_CTRL    = 3'd5
    } reg_ofs_e;

    // bit within the high bank that mirrors the low-bank summary
    localparam int SUMMARY_BIT = 1;
    // bit within the high bank carrying the pen-down source
    localparam int PEN_BIT = 4;
    // route byte bit that selects the direct line for pen-down (0 = direct)
    localparam int PEN_ROUTE_BIT = 1;
    // high-bank bits excluded from priority and cascade
    localparam logic [BYTE_W-1:0] HI_SKIP = (BYTE_W'(1) << SUMMARY_BIT) | (BYTE_W'(1) << PEN_BIT);
endpackage

// File: rtl/cic_pick.sv
module cic_pick #(
    parameter int W = 8,
    parameter logic [W-1:0] SKIP = '0,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     stat_n,
    input  logic [W-1:0]     mask,
    output logic [W-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [W-1:0] forced;

    always_comb begin
        forced = stat_n | mask | SKIP;
        req    = ~forced;
        any    = 1'b0;
        idx    = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/cic_regs.sv
module cic_regs
    import cic_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  lo_stat,
    input  logic [W-1:0]  hi_stat,
    output logic [W-1:0]  lo_mask,
    output logic [W-1:0]  hi_mask,
    output logic [W-1:0]  route,
    output logic [W-1:0]  ctrl,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] rd_mux;

    always_comb begin
        unique case (addr)
            OFS_LO_MASK: rd_mux = lo_mask;
            OFS_LO_STAT: rd_mux = lo_stat;
            OFS_ROUTE:   rd_mux = route;
            OFS_HI_MASK: rd_mux = hi_mask;
            OFS_HI_STAT: rd_mux = hi_stat;
            OFS_CTRL:    rd_mux = ctrl;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_mask <= '1;
            hi_mask <= '1;
            route   <= '1;
            ctrl    <= '0;
            rdata   <= '0;
        end else begin
            if (wr) begin
                unique case (addr)
                    OFS_LO_MASK: lo_mask <= wdata;
                    OFS_ROUTE:   route   <= wdata;
                    OFS_HI_MASK: hi_mask <= wdata;
                    OFS_CTRL:    ctrl    <= wdata;
                    default: ;
                endcase
            end
            if (rd) rdata <= rd_mux;
        end
    end

    a_r2_lo_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_LO_MASK) |=> lo_mask == $past(wdata));
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
    a_r3_status_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == OFS_LO_STAT || addr == OFS_HI_STAT)) |=>
            $stable(lo_mask) && $stable(hi_mask) && $stable(route) && $stable(ctrl));
endmodule

// File: rtl/cic_top.sv
module cic_top
    import cic_pkg::*;
#(
    parameter int BANK_W = BYTE_W,
    localparam int IDX_W = $clog2(BANK_W),
    localparam int SRC_N = 2 * BANK_W,
    localparam int ID_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    input  logic [SRC_N-1:0]  src_n,
    output logic              cascade_irq,
    output logic              direct_irq,
    output logic              pick_valid,
    output logic [ID_W-1:0]   pick_id
);
    logic [BANK_W-1:0] lo_mask, hi_mask, route, ctrl;
    logic [BANK_W-1:0] hi_stat_view;
    logic [BANK_W-1:0] bank_mask [2];
    logic [BANK_W-1:0] bank_req  [2];
    logic              bank_any  [2];
    logic [IDX_W-1:0]  bank_idx  [2];

    assign bank_mask[0] = lo_mask;
    assign bank_mask[1] = hi_mask;

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            cic_pick #(
                .W    (BANK_W),
                .SKIP ((b == 0) ? BANK_W'(0) : HI_SKIP)
            ) u_pick (
                .stat_n (src_n[b*BANK_W +: BANK_W]),
                .mask   (bank_mask[b]),
                .req    (bank_req[b]),
                .any    (bank_any[b]),
                .idx    (bank_idx[b])
            );
        end
    endgenerate

    always_comb begin
        hi_stat_view = src_n[SRC_N-1:BANK_W];
        hi_stat_view[SUMMARY_BIT] = ~bank_any[0];
    end

    cic_regs #(.W(BANK_W), .AW(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .lo_stat (src_n[BANK_W-1:0]),
        .hi_stat (hi_stat_view),
        .lo_mask (lo_mask),
        .hi_mask (hi_mask),
        .route   (route),
        .ctrl    (ctrl),
        .rdata   (bus_rdata)
    );

    always_comb begin
        pick_valid = bank_any[0] | bank_any[1];
        if (bank_any[0])      pick_id = {1'b0, bank_idx[0]};
        else if (bank_any[1]) pick_id = {1'b1, bank_idx[1]};
        else                  pick_id = '0;
    end

    assign cascade_irq = (|bank_req[0]) | (|bank_req[1]);
    assign direct_irq  = ~src_n[BANK_W + PEN_BIT] & ~route[PEN_ROUTE_BIT];

    a_r10_cascade_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_irq == pick_valid);
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_valid |-> pick_id == '0);
    a_r6_lo_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_n[0] && !lo_mask[0]) |-> (pick_valid && pick_id == '0));
    a_r8_skip_bits: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (pick_id != ID_W'(BANK_W + SUMMARY_BIT) && pick_id != ID_W'(BANK_W + PEN_BIT)));
    a_r5_lo_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_valid && !pick_id[ID_W-1]) |-> (!lo_mask[pick_id[IDX_W-1:0]] && !src_n[pick_id[IDX_W-1:0]]));
    a_r7_hi_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_valid && pick_id[ID_W-1]) |-> (!hi_mask[pick_id[IDX_W-1:0]] && !src_n[pick_id]));
endmodule

// File: tb/sim_cic_top.sv
module sim_cic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] src_n = 16'hFFFF;
    logic        cascade_irq, direct_irq, pick_valid;
    logic [3:0]  pick_id;
    int nchk = 0;
    int nfail = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    cic_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_n(src_n), .cascade_irq(cascade_irq), .direct_irq(direct_irq),
        .pick_valid(pick_valid), .pick_id(pick_id)
    );

    // {src_n, lo_mask, hi_mask, exp_cascade, exp_valid, exp_id}
    localparam logic [37:0] VEC [12] = '{
        {16'hFFFF, 8'h00, 8'h00, 1'b0, 1'b0, 4'd0},
        {16'hFFF7, 8'h00, 8'h00, 1'b1, 1'b1, 4'd3},
        {16'hFFF6, 8'h00, 8'h00, 1'b1, 1'b1, 4'd0},
        {16'hFFF6, 8'h01, 8'h00, 1'b1, 1'b1, 4'd3},
        {16'hFFF6, 8'hFF, 8'h00, 1'b0, 1'b0, 4'd0},
        {16'hFEFF, 8'h00, 8'h00, 1'b1, 1'b1, 4'd8},
        {16'hFEF7, 8'h00, 8'h00, 1'b1, 1'b1, 4'd3},
        {16'hFDFF, 8'h00, 8'h00, 1'b0, 1'b0, 4'd0},
        {16'hEFFF, 8'h00, 8'h00, 1'b0, 1'b0, 4'd0},
        {16'h7FFF, 8'h00, 8'h00, 1'b1, 1'b1, 4'd15},
        {16'h7EFF, 8'h00, 8'h01, 1'b1, 1'b1, 4'd15},
        {16'hE9FF, 8'h00, 8'h00, 1'b1, 1'b1, 4'd10}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #400000;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 cascade", 16'(cascade_irq), 16'h0);
        chk("R1 direct", 16'(direct_irq), 16'h0);
        chk("R1 valid", 16'(pick_valid), 16'h0);
        rd(3'd0, rv); chk("R1 lo mask", 16'(rv), 16'hFF);
        rd(3'd2, rv); chk("R1 route", 16'(rv), 16'hFF);
        rd(3'd3, rv); chk("R1 hi mask", 16'(rv), 16'hFF);
        rd(3'd5, rv); chk("R1 ctrl", 16'(rv), 16'h00);

        // vector table: R5 R6 R7 R8 R10 R11
        for (int i = 0; i < 12; i++) begin
            wr(3'd0, VEC[i][21:14]);
            wr(3'd3, VEC[i][13:6]);
            src_n = VEC[i][37:22];
            #1;
            chk("R5 R6 R7 R8 R10 cascade", 16'(cascade_irq), 16'(VEC[i][5]));
            chk("R5 R6 R7 R8 R11 valid", 16'(pick_valid), 16'(VEC[i][4]));
            chk("R6 R7 R11 id", 16'(pick_id), 16'(VEC[i][3:0]));
        end

        // R2 readback and data hold
        wr(3'd5, 8'h5A);
        rd(3'd5, rv); chk("R2 ctrl", 16'(rv), 16'h5A);
        @(negedge clk); chk("R2 hold", 16'(bus_rdata), 16'h5A);
        wr(3'd6, 8'h77);
        rd(3'd6, rv); chk("R2 unused", 16'(rv), 16'h00);

        // R3 status read-only
        src_n = 16'hFFA5;
        wr(3'd1, 8'h00);
        rd(3'd1, rv); chk("R3 lo stat", 16'(rv), 16'hA5);
        wr(3'd4, 8'h00);
        src_n = 16'hFFFF;
        rd(3'd4, rv); chk("R3 hi stat", 16'(rv), 16'hFF);

        // R4 summary bit
        wr(3'd0, 8'h00);
        src_n = 16'hFFFE;
        rd(3'd4, rv); chk("R4 summary on", 16'(rv), 16'hFD);
        wr(3'd0, 8'hFF);
        rd(3'd4, rv); chk("R4 summary masked", 16'(rv), 16'hFF);
        src_n = 16'hFDFF;
        rd(3'd4, rv); chk("R4 input bit1 hidden", 16'(rv), 16'hFF);

        // R9 direct line
        src_n = 16'hEFFF;
        wr(3'd3, 8'hFF);
        #1; chk("R9 route ff", 16'(direct_irq), 16'h0);
        wr(3'd2, 8'hFD);
        #1; chk("R9 route fd", 16'(direct_irq), 16'h1);
        chk("R8 pen no cascade", 16'(cascade_irq), 16'h0);
        src_n = 16'hFFFF;
        #1; chk("R9 released", 16'(direct_irq), 16'h0);
        rd(3'd2, rv); chk("R2 route", 16'(rv), 16'hFD);

        // R10 acknowledge by mask
        wr(3'd0, 8'h00);
        src_n = 16'hFFF7;
        #1; chk("R10 pending", 16'(cascade_irq), 16'h1);
        wr(3'd0, 8'h08);
        #1; chk("R10 ack", 16'(cascade_irq), 16'h0);
        chk("R11 idle id", 16'(pick_id), 16'h0);
        wr(3'd0, 8'h00);
        #1; chk("R10 reenable", 16'(cascade_irq), 16'h1);
        chk("R7 id", 16'(pick_id), 16'h3);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule